// File: doc/BRIEF.md
# Bus Address Parity Error Responder

This block watches the address phase of a multiplexed PCI-style bus and, in PCI-X mode, the attribute phase that follows it. It checks even parity across the address/data and command/byte-enable lines, using the parity line value that arrives one clock after each phase. It then decides how the target side must answer. A failed check can ask the target state machine for a target abort and can pulse the active-low system-error line. It also sets sticky status bits, which software clears by writing 1 to them.

The response depends on the bus command that was captured in the address phase. Reads, I/O accesses and configuration accesses can be aborted. Memory writes and split completions always finish normally. Two command-register controls gate the response: parity error response and system-error enable. The detected-parity flag is set whatever those controls are. The checker holds a small state machine. That machine is back in its idle state once each verdict is given, whether or not an error was found.

Top module: `addr_par_guard`

## Requirements
- R1: Parity is even. A phase is in error when `parIn`, sampled one clock after the phase, differs from the XOR of the 32 `adIn` lines and 4 `cmdBeIn` lines of that phase. Any address or attribute error sets `status[15]` (detected parity), whatever the control inputs are.
- R2: In conventional mode (`pcixMode`=0) only the address phase is checked, and the parity of the following cycle is ignored. In PCI-X mode (`pcixMode`=1, sampled with `addrValid`) the attribute phase in the cycle after the address is checked too.
- R3: For I/O Read 0010, I/O Write 0011, Memory Read 0110, Configuration Read 1010 and Configuration Write 1011 (`cmdBeIn` in the address phase), an error with `perrRespEn`=1 raises `tgtAbortReq` for exactly one clock. In conventional mode it is raised in the cycle after the parity sample for the address. In PCI-X mode it is raised in the cycle after the parity sample for the attribute phase.
- R4: With `perrRespEn`=0 no transaction is aborted.
- R5: Memory Write 0111 and Split Completion 1100 are never aborted, under any control settings. Any command code not listed in R3 is treated the same way.
- R6: Every abort sets `status[11]` (signaled target abort) in the same cycle that `tgtAbortReq` rises.
- R7: An error with both `serrEn`=1 and `perrRespEn`=1 drives `serrN` low for exactly one clock, aligned with the cycle R3 gives. It also sets `status[14]` (system error signaled).
- R8: `serrN` stays high when either `serrEn` or `perrRespEn` is 0.
- R9: Status bits are sticky. A write with `statWrEn`=1 clears each bit whose `statWrData` bit is 1. When a set and a clear hit the same bit in the same cycle, the set wins.
- R10: The checker is idle again after each verdict. A new `addrValid` two cycles after the previous one (conventional mode) is accepted and checked.
- R11: A transaction with correct parity produces no abort, no system error and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | High in the address phase of a transaction |
| adIn | input | 32 | Multiplexed address/data lines |
| cmdBeIn | input | 4 | Command/byte-enable lines |
| parIn | input | 1 | Parity line, one clock behind the phase it covers |
| pcixMode | input | 1 | 1 = PCI-X mode (attribute phase checked) |
| perrRespEn | input | 1 | Parity error response control |
| serrEn | input | 1 | System-error enable control |
| statWrEn | input | 1 | Status write strobe |
| statWrData | input | 16 | Write-1-to-clear mask for status |
| tgtAbortReq | output | 1 | One-clock target-abort request |
| serrN | output | 1 | Active-low one-clock system-error strobe |
| status | output | 16 | Sticky status: bit 15 detected parity, bit 14 system error, bit 11 target abort |

## Verification
Two cases are hard to reach from the ports. The first is a clear from software landing on the very cycle a verdict sets a status bit. The second is a second transaction starting the first cycle the checker is idle again. The stimulus task can place a write-1-to-clear exactly on the verdict cycle of either mode. A dedicated sequence starts two faulty conventional reads two cycles apart. A PCI-X case that is clean in the address phase and bad only in the attribute phase shows the second-phase error is kept. The matching conventional case shows that a bad parity bit in the following cycle is ignored.

// File: rtl/addr_par_pkg.sv
package addr_par_pkg;
  localparam int AD_W   = 32;
  localparam int CBE_W  = 4;
  localparam int STAT_W = 16;

  localparam int STA_BIT = 11;
  localparam int SSE_BIT = 14;
  localparam int DPE_BIT = 15;

  localparam logic [CBE_W-1:0] CMD_IO_RD  = 4'b0010;
  localparam logic [CBE_W-1:0] CMD_IO_WR  = 4'b0011;
  localparam logic [CBE_W-1:0] CMD_MEM_RD = 4'b0110;
  localparam logic [CBE_W-1:0] CMD_CFG_RD = 4'b1010;
  localparam logic [CBE_W-1:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ATTR = 2'd2
  } chkState_e;

  typedef struct packed {
    logic captureCmd;
    logic holdAddrErr;
    logic flagParity;
    logic signalAbort;
    logic signalSerr;
  } chkStrobe_t;

  function automatic logic isAbortable(input logic [CBE_W-1:0] cmd);
    return (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR) || (cmd == CMD_MEM_RD) ||
           (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  endfunction
endpackage

// File: rtl/addr_par_ctrl.sv
module addr_par_ctrl
  import addr_par_pkg::*;
#(
  parameter int CMD_W = CBE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrValid,
  input  logic             pcixMode,
  input  logic             perrRespEn,
  input  logic             serrEn,
  input  logic             phaseErr,
  input  logic             addrErrQ,
  input  logic [CMD_W-1:0] cmdQ,
  output chkStrobe_t       strobe
);
  chkState_e state, stateNext;
  logic      modeQ;
  logic      anyErr;
  logic      decide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.captureCmd) modeQ <= pcixMode;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    anyErr    = 1'b0;
    decide    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (addrValid) begin
          strobe.captureCmd = 1'b1;
          stateNext         = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (modeQ) begin
          strobe.holdAddrErr = 1'b1;
          stateNext          = ST_ATTR;
        end else begin
          decide    = 1'b1;
          anyErr    = phaseErr;
          stateNext = ST_IDLE;
        end
      end
      ST_ATTR: begin
        decide    = 1'b1;
        anyErr    = phaseErr | addrErrQ;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (decide && anyErr) begin
      strobe.flagParity  = 1'b1;
      strobe.signalAbort = perrRespEn & isAbortable(cmdQ);
      strobe.signalSerr  = perrRespEn & serrEn;
    end
  end

  // R10: a verdict always leaves the checker idle
  a_r10_idle_after_attr: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ATTR) |=> (state == ST_IDLE));

  // R2: conventional mode gives its verdict straight after the address parity
  a_r2_conv_single_phase: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && !modeQ) |=> (state == ST_IDLE));
endmodule

// File: rtl/addr_par_datapath.sv
module addr_par_datapath
  import addr_par_pkg::*;
#(
  parameter int AW    = AD_W,
  parameter int CW    = CBE_W,
  parameter int SW    = STAT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] adIn,
  input  logic [CW-1:0] cmdBeIn,
  input  logic          parIn,
  input  logic          statWrEn,
  input  logic [SW-1:0] statWrData,
  input  chkStrobe_t    strobe,
  output logic          phaseErr,
  output logic          addrErrQ,
  output logic [CW-1:0] cmdQ,
  output logic          tgtAbortReq,
  output logic          serrN,
  output logic [SW-1:0] status
);
  logic          prevParQ;
  logic [SW-1:0] setMask;
  logic [SW-1:0] clrMask;

  assign phaseErr = parIn ^ prevParQ;

  always_comb begin
    setMask          = '0;
    setMask[DPE_BIT] = strobe.flagParity;
    setMask[STA_BIT] = strobe.signalAbort;
    setMask[SSE_BIT] = strobe.signalSerr;
    clrMask          = statWrEn ? statWrData : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevParQ    <= 1'b0;
      cmdQ        <= '0;
      addrErrQ    <= 1'b0;
      tgtAbortReq <= 1'b0;
      serrN       <= 1'b1;
      status      <= '0;
    end else begin
      prevParQ    <= ^{adIn, cmdBeIn};
      if (strobe.captureCmd)  cmdQ     <= cmdBeIn;
      if (strobe.holdAddrErr) addrErrQ <= phaseErr;
      tgtAbortReq <= strobe.signalAbort;
      serrN       <= ~strobe.signalSerr;
      status      <= (status & ~clrMask) | setMask;
    end
  end

  // R7: system error is a single-clock strobe
  a_r7_serr_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    !serrN |=> serrN);

  // R6: an abort is always recorded in status
  a_r6_abort_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    tgtAbortReq |-> status[STA_BIT]);

  // R7: system error is always recorded in status
  a_r7_serr_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    !serrN |-> status[SSE_BIT]);

  // R1: any response implies detected parity
  a_r1_response_has_dpe: assert property (@(posedge clk) disable iff (!rstN)
    (tgtAbortReq || !serrN) |-> status[DPE_BIT]);
endmodule

// File: rtl/addr_par_guard.sv
module addr_par_guard
  import addr_par_pkg::*;
#(
  parameter int AW = AD_W,
  parameter int CW = CBE_W,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          addrValid,
  input  logic [AW-1:0] adIn,
  input  logic [CW-1:0] cmdBeIn,
  input  logic          parIn,
  input  logic          pcixMode,
  input  logic          perrRespEn,
  input  logic          serrEn,
  input  logic          statWrEn,
  input  logic [SW-1:0] statWrData,
  output logic          tgtAbortReq,
  output logic          serrN,
  output logic [SW-1:0] status
);
  chkStrobe_t    strobe;
  logic          phaseErr;
  logic          addrErrQ;
  logic [CW-1:0] cmdQ;

  addr_par_ctrl #(.CMD_W(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .pcixMode(pcixMode),
    .perrRespEn(perrRespEn), .serrEn(serrEn), .phaseErr(phaseErr),
    .addrErrQ(addrErrQ), .cmdQ(cmdQ), .strobe(strobe)
  );

  addr_par_datapath #(.AW(AW), .CW(CW), .SW(SW)) u_dp (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cmdBeIn(cmdBeIn), .parIn(parIn),
    .statWrEn(statWrEn), .statWrData(statWrData), .strobe(strobe),
    .phaseErr(phaseErr), .addrErrQ(addrErrQ), .cmdQ(cmdQ),
    .tgtAbortReq(tgtAbortReq), .serrN(serrN), .status(status)
  );

  // R4: no abort unless parity error response was enabled at the verdict
  a_r4_abort_needs_perr: assert property (@(posedge clk) disable iff (!rstN)
    tgtAbortReq |-> $past(perrRespEn));

  // R8: system error needs both controls
  a_r8_serr_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    !serrN |-> $past(serrEn && perrRespEn));
endmodule

// File: tb/addr_par_guard_bench.sv
module addr_par_guard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0;
  logic [31:0] adIn = '0;
  logic [3:0]  cmdBeIn = '0;
  logic        parIn = 1'b0;
  logic        pcixMode = 1'b0;
  logic        perrRespEn = 1'b0;
  logic        serrEn = 1'b0;
  logic        statWrEn = 1'b0;
  logic [15:0] statWrData = '0;
  logic        tgtAbortReq;
  logic        serrN;
  logic [15:0] status;

  int total = 0;
  int bad = 0;
  int abortSeen = 0;
  int serrSeen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_par_guard u_addr_par_guard (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .adIn(adIn), .cmdBeIn(cmdBeIn),
    .parIn(parIn), .pcixMode(pcixMode), .perrRespEn(perrRespEn), .serrEn(serrEn),
    .statWrEn(statWrEn), .statWrData(statWrData), .tgtAbortReq(tgtAbortReq),
    .serrN(serrN), .status(status)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int         mPhase = 0;
  bit         mMode, mAddrErr, mPrevPar, mErr, mDec, mCur;
  bit [3:0]   mCmd;
  bit         eAbort = 0, eSerrN = 1;
  bit [15:0]  eStat = '0, mSets;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mMode = 0; mAddrErr = 0; mPrevPar = 0; mCmd = 0;
      eAbort = 0; eSerrN = 1; eStat = '0;
    end else begin
      mCur = parIn ^ mPrevPar;
      mDec = 0; mErr = 0; mSets = '0;
      eAbort = 0; eSerrN = 1;
      if (mPhase == 0) begin
        if (addrValid) begin mPhase = 1; mMode = pcixMode; mCmd = cmdBeIn; end
      end else if (mPhase == 1) begin
        if (mMode) begin mAddrErr = mCur; mPhase = 2; end
        else begin mDec = 1; mErr = mCur; mPhase = 0; end
      end else begin
        mDec = 1; mErr = mCur | mAddrErr; mPhase = 0;
      end
      if (mDec && mErr) begin
        mSets[15] = 1;
        if (perrRespEn && (mCmd inside {4'h2, 4'h3, 4'h6, 4'hA, 4'hB})) begin
          eAbort = 1; mSets[11] = 1;
        end
        if (perrRespEn && serrEn) begin eSerrN = 0; mSets[14] = 1; end
      end
      eStat = (eStat & ~(statWrEn ? statWrData : 16'h0)) | mSets;
      mPrevPar = ^{adIn, cmdBeIn};
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(tgtAbortReq == eAbort, "R3 model abort", tgtAbortReq, eAbort);
      check(serrN == eSerrN, "R7 model serr", serrN, eSerrN);
      check(status == eStat, "R9 model status", status, eStat);
      abortSeen += tgtAbortReq;
      serrSeen  += !serrN;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addrValid = 0; adIn = '0; cmdBeIn = '0; parIn = 0; statWrEn = 0; statWrData = '0;
    end
  endtask

  task automatic clearAll();
    @(negedge clk);
    statWrEn = 1; statWrData = 16'hFFFF;
    idle(1);
    abortSeen = 0; serrSeen = 0;
  endtask

  // one transaction; clrAt: 0 none, else write-1-clear all in the verdict cycle
  task automatic runTxn(input bit [3:0] cmd, input bit mode, input bit pe, input bit se,
                        input bit badA, input bit badB, input bit clrAt);
    bit [31:0] a, b;
    bit [3:0]  attr;
    a = $urandom; b = $urandom; attr = 4'($urandom);
    @(negedge clk);
    pcixMode = mode; perrRespEn = pe; serrEn = se;
    addrValid = 1; adIn = a; cmdBeIn = cmd; parIn = 0; statWrEn = 0;
    @(negedge clk);
    addrValid = 0; adIn = b; cmdBeIn = attr; parIn = (^{a, cmd}) ^ badA;
    statWrEn = clrAt && !mode; statWrData = 16'hFFFF;
    @(negedge clk);
    adIn = '0; cmdBeIn = '0; parIn = (^{b, attr}) ^ badB;
    statWrEn = clrAt && mode;
    idle(3);
  endtask

  task automatic scen(input string tag, input bit [3:0] cmd, input bit mode, input bit pe,
                      input bit se, input bit badA, input bit badB,
                      input int expAb, input int expSe, input bit [15:0] expSt);
    clearAll();
    runTxn(cmd, mode, pe, se, badA, badB, 0);
    check(abortSeen == expAb, {tag, " abort count"}, abortSeen, expAb);
    check(serrSeen == expSe, {tag, " serr count"}, serrSeen, expSe);
    check(status == expSt, {tag, " status"}, status, expSt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tgtAbortReq == 0 && serrN == 1 && status == 0, "R11 reset state",
          {tgtAbortReq, serrN, status}, 17'h10000);
    rstN = 1;
    idle(2);
    // R11 clean transactions
    scen("R11 clean memrd", 4'h6, 0, 1, 1, 0, 0, 0, 0, 16'h0);
    scen("R11 clean pcix cfgrd", 4'hA, 1, 1, 1, 0, 0, 0, 0, 16'h0);
    // R3 aborts, conventional and PCI-X
    scen("R3 conv memrd", 4'h6, 0, 1, 0, 1, 0, 1, 0, 16'h8800);
    scen("R3 conv iowr", 4'h3, 0, 1, 0, 1, 0, 1, 0, 16'h8800);
    scen("R6 cfgwr sta bit", 4'hB, 0, 1, 0, 1, 0, 1, 0, 16'h8800);
    scen("R3 pcix iord addr err", 4'h2, 1, 1, 0, 1, 0, 1, 0, 16'h8800);
    // R2 attribute phase only in PCI-X
    scen("R2 pcix attr err", 4'hA, 1, 1, 0, 0, 1, 1, 0, 16'h8800);
    scen("R2 conv attr ignored", 4'hA, 0, 1, 1, 0, 1, 0, 0, 16'h0);
    // R4 response disabled
    scen("R4 perr off", 4'h6, 0, 0, 1, 1, 0, 0, 0, 16'h8000);
    scen("R1 dpe with controls off", 4'h2, 1, 0, 0, 0, 1, 0, 0, 16'h8000);
    // R5 writes and completions
    scen("R5 memwr", 4'h7, 0, 1, 0, 1, 0, 0, 0, 16'h8000);
    scen("R5 split completion", 4'hC, 1, 1, 1, 1, 1, 0, 1, 16'hC000);
    scen("R5 other cmd", 4'hE, 0, 1, 0, 1, 0, 0, 0, 16'h8000);
    // R7 / R8 system error
    scen("R7 serr both", 4'h6, 0, 1, 1, 1, 0, 1, 1, 16'hC800);
    scen("R8 serr only enable", 4'h6, 0, 0, 1, 1, 0, 0, 0, 16'h8000);
    scen("R8 perr only", 4'h7, 1, 1, 0, 1, 0, 0, 0, 16'h8000);
    // R9 clear coinciding with set: set wins
    clearAll();
    runTxn(4'h6, 0, 1, 1, 1, 0, 1);
    check(status == 16'hC800, "R9 set wins conv", status, 16'hC800);
    clearAll();
    runTxn(4'hA, 1, 1, 0, 0, 1, 1);
    check(status == 16'h8800, "R9 set wins pcix", status, 16'h8800);
    @(negedge clk);
    statWrEn = 1; statWrData = 16'h0800;
    idle(1);
    check(status == 16'h8000, "R9 partial clear", status, 16'h8000);
    // R10 back-to-back conventional transactions
    clearAll();
    begin
      bit [31:0] a, c;
      a = $urandom; c = $urandom;
      @(negedge clk);
      pcixMode = 0; perrRespEn = 1; serrEn = 0;
      addrValid = 1; adIn = a; cmdBeIn = 4'h6;
      @(negedge clk);
      addrValid = 0; adIn = '0; cmdBeIn = '0; parIn = ~(^{a, 4'h6});
      @(negedge clk);
      addrValid = 1; adIn = c; cmdBeIn = 4'hA; parIn = 0;
      @(negedge clk);
      addrValid = 0; adIn = '0; cmdBeIn = '0; parIn = ~(^{c, 4'hA});
      idle(3);
    end
    check(abortSeen == 2, "R10 back-to-back aborts", abortSeen, 2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule